// File: doc/BRIEF.md
# Word-Parallel Serializer with Internal Loopback

This block turns a stream of 10-bit pre-coded words into a serial bit stream. Each word is captured on the rising edge of a word-rate reference clock and then shifted out one bit per tick of a bit clock that runs ten times faster, lowest bit first. Successive words follow one another with no idle bit and no repeated bit, so the line carries one continuous stream. The block does no line coding and no clock generation: both clocks are primary inputs, and they come from a common source. The reference clock's rising edge falls midway between two rising edges of the bit clock.

A loopback select steers the serial stream to an internal output that feeds a local receiver. While loopback is in force, the external line output is held at a constant low level. The routing choice is sampled only when a new word enters the shifter, so a word is never split between the two outputs.

Top module: `ser_loop_tx`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_bit`, both `line_out` and `loop_out` are 0 after that edge. They stay 0 until the first word is loaded.
- R2: `tx_word` is captured only at a rising edge of `clk_ref`. Changes to `tx_word` between two such edges do not alter the bits sent for the captured word.
- R3: With `LSB_FIRST=1`, bit 0 of a word is sent first and bit 9 last, in ascending order, one bit per `clk_bit` tick.
- R4: Words captured on consecutive `clk_ref` edges leave back to back. A new word enters the shifter exactly every `WORD_W` bit ticks, with no gap and no repeated bit.
- R5: When `loop_en` was 1 at a word's load tick, that word's bits appear on `loop_out` and `line_out` stays 0 for all of its bit times.
- R6: When `loop_en` was 0 at a word's load tick, that word's bits appear on `line_out` and `loop_out` stays 0 for all of its bit times.
- R7: `loop_en` is sampled only on the load tick. A change of `loop_en` in the middle of a word leaves that word's routing unchanged.
- R8: With `SYNC_STAGES=1`, bit 0 of a word is on the output after the second rising edge of `clk_bit` that follows the `clk_ref` rising edge capturing it. Bit 9 is on the output after the eleventh such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock; one serial bit per rising edge |
| clk_ref | input | 1 | Word-rate reference clock, one tenth of the bit rate |
| rst | input | 1 | Synchronous active-high reset, bit-clock domain |
| tx_word | input | WORD_W | Pre-coded parallel word |
| loop_en | input | 1 | 1 routes the stream to `loop_out`; 0 routes it to `line_out` |
| line_out | output | 1 | External serial output |
| loop_out | output | 1 | Internal loopback serial output |

## Verification
The bench builds the block with its defaults: `WORD_W=10`, `SYNC_STAGES=1`, `LSB_FIRST=1` and an idle level of 0. With these values the load tick falls two bit edges after each reference edge, which gives R8 an exact cycle to check. The ten-bit width lets the bench send patterns such as all ones, a single set bit at either end, and alternating bits, which expose a reversed or shifted order. Because the idle level is 0, the two outputs can never both be high, and that property is checked throughout the run.

// File: rtl/ser_pkg.sv
package ser_pkg;
   // Routing of the serial stream for the word currently in the shifter
   typedef enum logic {
      PATH_LINE = 1'b0,
      PATH_LOOP = 1'b1
   } path_e;

   // Width needed to count up to a given value
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/ser_ref_capture.sv
module ser_ref_capture #(
   parameter int WORD_W = 10
) (
   input  logic              clk_ref,
   input  logic [WORD_W-1:0] d_in,
   output logic [WORD_W-1:0] q_out
);
   if (WORD_W < 2) begin : g_bad_width
      $error("ser_ref_capture: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk_ref) begin
      word_q <= d_in;
   end

   assign q_out = word_q;
endmodule

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl_in,
   output logic rise_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("ser_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES:0] chain_q;

   if (STAGES == 1) begin : g_short
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[0], lvl_in};
      end
   end else begin : g_long
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[STAGES-1:0], lvl_in};
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R4
   rise_not_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
   import ser_pkg::*;
#(
   parameter int WORD_W    = 10,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] d_in,
   output logic              bit_o
);
   localparam int RW = WORD_W - 1;
   localparam int CW = cnt_width(WORD_W);

   logic          bit_q;
   logic [RW-1:0] rest_q;

   if (LSB_FIRST) begin : g_lsb
      always_ff @(posedge clk) begin
         if (rst) begin
            bit_q  <= 1'b0;
            rest_q <= '0;
         end else if (load) begin
            bit_q  <= d_in[0];
            rest_q <= d_in[WORD_W-1:1];
         end else begin
            bit_q  <= rest_q[0];
            rest_q <= rest_q >> 1;
         end
      end
   end else begin : g_msb
      always_ff @(posedge clk) begin
         if (rst) begin
            bit_q  <= 1'b0;
            rest_q <= '0;
         end else if (load) begin
            bit_q  <= d_in[WORD_W-1];
            rest_q <= d_in[WORD_W-2:0];
         end else begin
            bit_q  <= rest_q[RW-1];
            rest_q <= rest_q << 1;
         end
      end
   end

   assign bit_o = bit_q;

   // Load spacing monitor
   logic [CW-1:0] gap_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (load) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != CW'(WORD_W)) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R4
   load_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (load && seen_q) |-> (gap_q == CW'(WORD_W - 1)));
endmodule

// File: rtl/ser_path_sel.sv
module ser_path_sel
   import ser_pkg::*;
#(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic boundary,
   input  logic loop_req,
   input  logic bit_in,
   output logic line_o,
   output logic loop_o
);
   path_e mode_q;

   always_ff @(posedge clk) begin
      if (rst)           mode_q <= PATH_LINE;
      else if (boundary) mode_q <= loop_req ? PATH_LOOP : PATH_LINE;
   end

   always_comb begin
      if (mode_q == PATH_LOOP) begin
         line_o = IDLE_LEVEL;
         loop_o = bit_in;
      end else begin
         line_o = bit_in;
         loop_o = 1'b0;
      end
   end

   // R7
   mode_word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(mode_q));

   if (IDLE_LEVEL == 1'b0) begin : g_excl
      // R5 R6
      single_path_chk: assert property (@(posedge clk) disable iff (rst)
         $onehot0({line_o, loop_o}));
   end
endmodule

// File: rtl/ser_loop_tx.sv
module ser_loop_tx
   import ser_pkg::*;
#(
   parameter int WORD_W      = 10,
   parameter int SYNC_STAGES = 1,
   parameter bit LSB_FIRST   = 1'b1,
   parameter bit IDLE_LEVEL  = 1'b0
) (
   input  logic              clk_bit,
   input  logic              clk_ref,
   input  logic              rst,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              loop_en,
   output logic              line_out,
   output logic              loop_out
);
   if (WORD_W < 2) begin : g_bad_width
      $error("ser_loop_tx: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("ser_loop_tx: SYNC_STAGES must be at least 1");
   end

   logic [WORD_W-1:0] word_held;
   logic              load_tick;
   logic              ser_bit;

   ser_ref_capture #(.WORD_W(WORD_W)) u_capture (
      .clk_ref (clk_ref),
      .d_in    (tx_word),
      .q_out   (word_held)
   );

   ser_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk_bit),
      .rst    (rst),
      .lvl_in (clk_ref),
      .rise_o (load_tick)
   );

   ser_shifter #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk   (clk_bit),
      .rst   (rst),
      .load  (load_tick),
      .d_in  (word_held),
      .bit_o (ser_bit)
   );

   ser_path_sel #(.IDLE_LEVEL(IDLE_LEVEL)) u_path (
      .clk      (clk_bit),
      .rst      (rst),
      .boundary (load_tick),
      .loop_req (loop_en),
      .bit_in   (ser_bit),
      .line_o   (line_out),
      .loop_o   (loop_out)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk_bit)
      rst |=> (!line_out && !loop_out));
endmodule

// File: tb/ser_loop_tx_tb.sv
module ser_loop_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 10;
   localparam int SYNC       = 1;

   typedef struct packed {
      int   idx;
      logic s;
      logic l;
   } exp_t;

   logic         clk_bit = 1'b0;
   logic         clk_ref = 1'b0;
   logic         rst     = 1'b1;
   logic [W-1:0] tx_word = '0;
   logic         loop_en = 1'b0;
   logic         line_out, loop_out;

   int   n_checks = 0;
   int   n_fails  = 0;
   int   pidx     = 0;
   bit   done     = 1'b0;
   exp_t q[$];

   ser_loop_tx #(.WORD_W(W), .SYNC_STAGES(SYNC)) u_dut (
      .clk_bit  (clk_bit),
      .clk_ref  (clk_ref),
      .rst      (rst),
      .tx_word  (tx_word),
      .loop_en  (loop_en),
      .line_out (line_out),
      .loop_out (loop_out)
   );

   always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

   // Monitor: compares outputs with queued expectations, 2 units after each edge
   initial begin
      forever begin
         @(posedge clk_bit);
         #2;
         pidx = pidx + 1;
         while (q.size() > 0 && q[0].idx == pidx) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            // R2 R3 R4 R5 R6 R7 R8
            if (line_out !== e.s || loop_out !== e.l) begin
               n_fails++;
               $display("FAIL R3,R5,R6,R8 edge %0d: line/loop actual %b%b expected %b%b",
                        pidx, line_out, loop_out, e.s, e.l);
            end
         end
      end
   end

   // Driver: one reference period per word, starting at a falling bit edge
   task automatic send_word(input logic [W-1:0] w, input logic lb, input bit glitch);
      int base;
      tx_word = w;
      loop_en = lb;
      #1;
      clk_ref = 1'b1;
      base = pidx;
      for (int j = 0; j < W; j++) begin
         exp_t e;
         e.idx = base + SYNC + 1 + j;
         e.s   = lb ? 1'b0 : w[j];
         e.l   = lb ? w[j] : 1'b0;
         q.push_back(e);
      end
      for (int k = 0; k < 5; k++) begin
         @(negedge clk_bit);
         if (glitch && k == 2) begin
            tx_word = ~w;      // R2: must not reach the line
            loop_en = ~lb;     // R7: must not reroute this word
         end
      end
      #1;
      clk_ref = 1'b0;
      for (int k = 0; k < 5; k++) @(negedge clk_bit);
   endtask

   task automatic check_quiet(input string tag);
      n_checks++;
      if (line_out !== 1'b0 || loop_out !== 1'b0) begin
         n_fails++;
         $display("FAIL %s: line/loop actual %b%b expected 00", tag, line_out, loop_out);
      end
   endtask

   initial begin
      logic [W-1:0] lfsr;
      repeat (4) @(negedge clk_bit);
      rst = 1'b0;
      // R1: quiet after reset, before any load
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_bit);
         #2;
         check_quiet("R1");
      end
      @(negedge clk_bit);
      // R3 R4 R6: line path, order-revealing patterns
      send_word(10'h0FA, 1'b0, 1'b0);
      send_word(10'h001, 1'b0, 1'b0);
      send_word(10'h200, 1'b0, 1'b0);
      send_word(10'h155, 1'b0, 1'b0);
      send_word(10'h3FF, 1'b0, 1'b0);
      // R5: loopback path
      send_word(10'h2AA, 1'b1, 1'b0);
      send_word(10'h305, 1'b1, 1'b0);
      send_word(10'h000, 1'b1, 1'b0);
      // R2 R7: mid-word changes of data and routing
      send_word(10'h0C3, 1'b1, 1'b1);
      send_word(10'h13C, 1'b0, 1'b1);
      send_word(10'h37E, 1'b0, 1'b1);
      // R4 R5 R6: mixed back-to-back stream
      lfsr = 10'h1A5;
      for (int n = 0; n < 24; n++) begin
         lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
         send_word(lfsr, logic'(n % 3 == 1), bit'(n % 5 == 4));
      end
      repeat (15) @(negedge clk_bit);
      n_checks++;
      if (q.size() != 0) begin
         n_fails++;
         $display("FAIL R4: pending expectations actual %0d expected 0", q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule